// File: doc/BRIEF.md
# Byte Load Decode and Address Generation Unit

This block executes one kind of memory instruction: a load of a single byte whose address comes from a base register and an immediate. It accepts a 32-bit instruction word and identifies which of three addressing forms the word uses. In the post-indexed form the access uses the base as it is, and the base then advances by a signed 9-bit offset. In the pre-indexed form the base is first moved by a signed 9-bit offset, and the access and the new base both use that moved address. In the plain offset form an unsigned 12-bit offset is added and the base register is left alone. Any other word is flagged as undecoded.

The register file and the memory sit outside the block. The block names the base register on a read index and takes its value back in the same cycle. A separate input carries the stack pointer, which is used when the base index is 31. The block then sends one byte read on a request/valid port and waits for the reply. In the cycle the byte arrives, it writes the byte, zero-extended to 32 bits, to the destination register. In that same cycle it writes the updated address back to the base general register or to the stack pointer, when the form asks for it.

While a load is in flight, `busy` is high and new instruction words are refused. If a stack-pointer base is not aligned to 16 bytes, the load is stopped before it reaches memory.

Top module: `byte_ld_agu`

## Requirements
- R1: Post-indexed form (bits [31:21] = 00111000010, bits [11:10] = 01, imm9 in [20:12], base index in [9:5], destination index in [4:0]): the memory address is the base value unchanged, and the base is written back as base plus the sign-extended imm9.
- R2: Pre-indexed form (same fields, bits [11:10] = 11): the memory address is base plus the sign-extended imm9, and the base is written back with that same address.
- R3: Unsigned offset form (bits [31:22] = 0011100101, imm12 in [21:10]): the memory address is base plus the zero-extended imm12 (0 to 4095), and no base write happens.
- R4: imm9 is read as two's complement across the full range -256 to +255. 0x100 means -256 and 0x0FF means +255.
- R5: A base index of 31 takes the base from `sp_in`, and any writeback goes out on `sp_we`/`sp_data`. Any other index takes the base from `rd_data` (with `rd_idx` equal to the index), and writeback goes out on `wb_we`/`wb_idx`/`wb_data`.
- R6: With base index 31 and `sp_in[3:0]` not zero, in any form, `align_fault` pulses for one cycle in the cycle after acceptance. No memory request is made, no register is written, and `busy` stays low.
- R7: `dst_data` is the returned byte in bits [7:0] with zeros in bits [31:8]. It is written to the destination index from the word.
- R8: When a form with writeback has base index equal to destination index and the index is not 31, only the destination write happens and the base write is dropped. Index 31 for both still writes the stack pointer.
- R9: A word that matches none of the three forms pulses `undecoded` for one cycle in the cycle after acceptance, with no request, no register write and `busy` low.
- R10: A word is accepted when `instr_valid` is high and `busy` is low. `mem_req` is high for exactly the one cycle after acceptance. `busy` stays high from then through the completion cycle, which is the first cycle after the request cycle in which `mem_rvalid` is high. All register writes happen only in that completion cycle. A word offered while `busy` is high is ignored.
- R11: After reset, `busy`, `mem_req`, `undecoded`, `align_fault` and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | A load is in flight; new words are refused |
| undecoded | output | 1 | One-cycle pulse: the word matched no form |
| align_fault | output | 1 | One-cycle pulse: stack-pointer base was misaligned |
| rd_idx | output | 5 | Base register read index |
| rd_data | input | 64 | Base general register value for rd_idx |
| sp_in | input | 64 | Current stack pointer |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 64 | Byte read address, held while busy |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Returned byte |
| dst_we | output | 1 | Destination register write enable |
| dst_idx | output | 5 | Destination register index |
| dst_data | output | 32 | Zero-extended loaded byte |
| wb_we | output | 1 | Base general register write enable |
| wb_idx | output | 5 | Base general register index |
| wb_data | output | 64 | Updated base address |
| sp_we | output | 1 | Stack pointer write enable |
| sp_data | output | 64 | Updated stack pointer |

## Verification
A wrong decode or a wrong offset extension shows up on `mem_addr` in the cycle after acceptance, because the address is latched when the word is accepted. A wrong saved writeback value or a wrong overlap flag stays hidden until the completion cycle, where it shows up as a wrong `wb_data`/`sp_data` value or as an enable that should not be there. A stuck controller state shows up as `busy` or `mem_req` holding past the one cycle each is allowed. It also shows up when a word offered during a load is accepted, which produces an extra request.

// File: rtl/byte_ld_pkg.sv
package byte_ld_pkg;

    localparam int XLEN    = 64;
    localparam int WLEN    = 32;
    localparam int IDXW    = 5;
    localparam int BYTEW   = 8;
    localparam int IMM9W   = 9;
    localparam int IMM12W  = 12;
    localparam logic [IDXW-1:0] SP_IDX = 5'd31;

    localparam logic [10:0] OPC_INDEXED = 11'b00111000010;
    localparam logic [9:0]  OPC_UOFS    = 10'b0011100101;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_POST = 2'd1,
        FORM_PRE  = 2'd2,
        FORM_UOFS = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } state_e;

    typedef struct packed {
        form_e             form;
        logic [IDXW-1:0]   base_idx;
        logic [IDXW-1:0]   dst_idx;
        logic [XLEN-1:0]   offset;
        logic              post;
        logic              wback;
    } dec_t;

    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        d          = '0;
        d.form     = FORM_NONE;
        d.base_idx = w[9:5];
        d.dst_idx  = w[4:0];
        if (w[31:21] == OPC_INDEXED && w[10]) begin
            d.form   = w[11] ? FORM_PRE : FORM_POST;
            d.offset = {{(XLEN-IMM9W){w[20]}}, w[20:12]};
            d.post   = !w[11];
            d.wback  = 1'b1;
        end else if (w[31:22] == OPC_UOFS) begin
            d.form   = FORM_UOFS;
            d.offset = {{(XLEN-IMM12W){1'b0}}, w[21:10]};
            d.post   = 1'b0;
            d.wback  = 1'b0;
        end
        // same base and destination on a general register: keep data, drop base update
        if (d.wback && d.base_idx == d.dst_idx && d.base_idx != SP_IDX)
            d.wback = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/byte_ld_decode.sv
module byte_ld_decode
    import byte_ld_pkg::*;
(
    input  logic [31:0] instr_word,
    output dec_t        dec,
    output logic        legal
);
    always_comb begin
        dec   = decode_word(instr_word);
        legal = (dec.form != FORM_NONE);
    end
endmodule

// File: rtl/byte_ld_agen.sv
module byte_ld_agen
    import byte_ld_pkg::*;
#(
    parameter int SP_ALIGN_LG2 = 4
) (
    input  dec_t             dec,
    input  logic [XLEN-1:0]  gpr_base,
    input  logic [XLEN-1:0]  sp_base,
    output logic [XLEN-1:0]  acc_addr,
    output logic [XLEN-1:0]  wb_addr,
    output logic             misalign
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] moved;
    logic            use_sp;

    always_comb begin
        use_sp   = (dec.base_idx == SP_IDX);
        base     = use_sp ? sp_base : gpr_base;
        moved    = base + dec.offset;
        acc_addr = dec.post ? base : moved;
        wb_addr  = moved;
        misalign = use_sp && (|sp_base[SP_ALIGN_LG2-1:0]);
    end
endmodule

// File: rtl/byte_ld_ctrl.sv
module byte_ld_ctrl
    import byte_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              legal,
    input  logic              misalign,
    input  dec_t              dec,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic [XLEN-1:0]   wb_addr,
    input  logic              mem_rvalid,
    input  logic [BYTEW-1:0]  mem_rdata,
    output logic              busy,
    output logic              undecoded,
    output logic              align_fault,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic              dst_we,
    output logic [IDXW-1:0]   dst_idx,
    output logic [WLEN-1:0]   dst_data,
    output logic              wb_we,
    output logic [IDXW-1:0]   wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_data
);
    state_e            state;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   wbv_q;
    logic              wback_q;
    logic [IDXW-1:0]   n_q;
    logic [IDXW-1:0]   t_q;
    logic              undec_q;
    logic              fault_q;
    logic              done;
    logic              base_is_sp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wbv_q   <= '0;
            wback_q <= 1'b0;
            n_q     <= '0;
            t_q     <= '0;
            undec_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            undec_q <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!legal) begin
                            undec_q <= 1'b1;
                        end else if (misalign) begin
                            fault_q <= 1'b1;
                        end else begin
                            addr_q  <= acc_addr;
                            wbv_q   <= wb_addr;
                            wback_q <= dec.wback;
                            n_q     <= dec.base_idx;
                            t_q     <= dec.dst_idx;
                            state   <= ST_REQ;
                        end
                    end
                end
                ST_REQ:  state <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        undecoded   = undec_q;
        align_fault = fault_q;
        mem_req     = (state == ST_REQ);
        mem_addr    = addr_q;
        done        = (state == ST_WAIT) && mem_rvalid;
        base_is_sp  = (n_q == SP_IDX);
        dst_we      = done;
        dst_idx     = t_q;
        dst_data    = {{(WLEN-BYTEW){1'b0}}, mem_rdata};
        wb_we       = done && wback_q && !base_is_sp;
        wb_idx      = n_q;
        wb_data     = wbv_q;
        sp_we       = done && wback_q && base_is_sp;
        sp_data     = wbv_q;
    end
endmodule

// File: rtl/byte_ld_agu.sv
module byte_ld_agu
    import byte_ld_pkg::*;
#(
    parameter int SP_ALIGN_LG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              busy,
    output logic              undecoded,
    output logic              align_fault,
    output logic [IDXW-1:0]   rd_idx,
    input  logic [XLEN-1:0]   rd_data,
    input  logic [XLEN-1:0]   sp_in,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [BYTEW-1:0]  mem_rdata,
    output logic              dst_we,
    output logic [IDXW-1:0]   dst_idx,
    output logic [WLEN-1:0]   dst_data,
    output logic              wb_we,
    output logic [IDXW-1:0]   wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_data
);
    dec_t            dec;
    logic            legal;
    logic [XLEN-1:0] acc_addr;
    logic [XLEN-1:0] wb_addr;
    logic            misalign;
    logic            start;

    byte_ld_decode u_dec (
        .instr_word (instr_word),
        .dec        (dec),
        .legal      (legal)
    );

    byte_ld_agen #(.SP_ALIGN_LG2(SP_ALIGN_LG2)) u_agen (
        .dec      (dec),
        .gpr_base (rd_data),
        .sp_base  (sp_in),
        .acc_addr (acc_addr),
        .wb_addr  (wb_addr),
        .misalign (misalign)
    );

    assign rd_idx = dec.base_idx;
    assign start  = instr_valid && !busy;

    byte_ld_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .legal       (legal),
        .misalign    (misalign),
        .dec         (dec),
        .acc_addr    (acc_addr),
        .wb_addr     (wb_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .undecoded   (undecoded),
        .align_fault (align_fault),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .dst_we      (dst_we),
        .dst_idx     (dst_idx),
        .dst_data    (dst_data),
        .wb_we       (wb_we),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .sp_we       (sp_we),
        .sp_data     (sp_data)
    );
endmodule

// File: rtl/byte_ld_agu_chk.sv
module byte_ld_agu_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        undecoded,
    input logic        align_fault,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_rvalid,
    input logic        dst_we,
    input logic        wb_we,
    input logic        sp_we
);
    a_r10_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r10_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r10_write_on_reply: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> (mem_rvalid && busy && !mem_req));

    a_r10_addr_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr));

    a_r10_done_frees: assert property (@(posedge clk) disable iff (rst)
        dst_we |=> !busy);

    a_r8_base_needs_dst: assert property (@(posedge clk) disable iff (rst)
        (wb_we || sp_we) |-> dst_we);

    a_r5_one_base_target: assert property (@(posedge clk) disable iff (rst)
        !(wb_we && sp_we));

    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> (!busy && !mem_req && !dst_we));

    a_r9_undec_quiet: assert property (@(posedge clk) disable iff (rst)
        undecoded |-> (!busy && !mem_req && !dst_we && !align_fault));
endmodule

bind byte_ld_agu byte_ld_agu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .undecoded   (undecoded),
    .align_fault (align_fault),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .dst_we      (dst_we),
    .wb_we       (wb_we),
    .sp_we       (sp_we)
);

// File: tb/tb_byte_ld_agu.sv
module tb_byte_ld_agu;
    localparam int CLK_PERIOD = 10;
    localparam int K_LOAD  = 0;
    localparam int K_UNDEC = 1;
    localparam int K_FAULT = 2;
    localparam int F_POST = 1;
    localparam int F_PRE  = 2;
    localparam int F_UOFS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        busy, undecoded, align_fault;
    logic [4:0]  rd_idx;
    logic [63:0] rd_data = '0;
    logic [63:0] sp_in = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        dst_we;
    logic [4:0]  dst_idx;
    logic [31:0] dst_data;
    logic        wb_we;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        sp_we;
    logic [63:0] sp_data;

    byte_ld_agu dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .busy(busy), .undecoded(undecoded), .align_fault(align_fault),
        .rd_idx(rd_idx), .rd_data(rd_data), .sp_in(sp_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
        .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
        .sp_we(sp_we), .sp_data(sp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          kind;
        string       req;
        logic [63:0] addr;
        logic [4:0]  t;
        logic [31:0] data;
        int          wb_kind;   // 0 none, 1 general register, 2 stack pointer
        logic [4:0]  n;
        logic [63:0] wbv;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   req_seen = 0;
    bit   finished = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(int form, logic [4:0] n, logic [4:0] t, logic [11:0] imm);
        if (form == F_POST) return {11'b00111000010, imm[8:0], 2'b01, n, t};
        if (form == F_PRE)  return {11'b00111000010, imm[8:0], 2'b11, n, t};
        return {10'b0011100101, imm, n, t};
    endfunction

    function automatic exp_t model(string req, int form, logic [4:0] n, logic [4:0] t,
                                   int imm, logic [63:0] gpr, logic [63:0] sp, logic [7:0] b);
        exp_t e;
        logic [63:0] base, moved;
        bit wb;
        e.req = req; e.t = t; e.n = n; e.data = {24'h0, b};
        base  = (n == 5'd31) ? sp : gpr;
        moved = base + 64'(longint'(imm));
        wb    = (form != F_UOFS) && !(n == t && n != 5'd31);
        if (n == 5'd31 && sp[3:0] != 4'h0) e.kind = K_FAULT;
        else e.kind = K_LOAD;
        e.addr    = (form == F_POST) ? base : moved;
        e.wbv     = moved;
        e.wb_kind = !wb ? 0 : (n == 5'd31 ? 2 : 1);
        return e;
    endfunction

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (mem_req) begin
                if (q.size() == 0 || q[0].kind != K_LOAD || req_seen)
                    chk("R10", "unexpected mem_req", 64'd1, 64'd0);
                else begin
                    chk(q[0].req, "mem_addr", mem_addr, q[0].addr);
                    req_seen = 1;
                end
            end
            if (dst_we) begin
                if (q.size() == 0 || q[0].kind != K_LOAD || !req_seen)
                    chk("R10", "unexpected dst_we", 64'd1, 64'd0);
                else begin
                    chk("R7", "dst_idx", 64'(dst_idx), 64'(q[0].t));
                    chk("R7", "dst_data", 64'(dst_data), 64'(q[0].data));
                    chk(q[0].req, "wb_we", 64'(wb_we), 64'(q[0].wb_kind == 1));
                    chk(q[0].req, "sp_we", 64'(sp_we), 64'(q[0].wb_kind == 2));
                    if (q[0].wb_kind == 1) begin
                        chk(q[0].req, "wb_idx", 64'(wb_idx), 64'(q[0].n));
                        chk(q[0].req, "wb_data", wb_data, q[0].wbv);
                    end
                    if (q[0].wb_kind == 2) chk(q[0].req, "sp_data", sp_data, q[0].wbv);
                    void'(q.pop_front());
                    req_seen = 0;
                end
            end else if (wb_we || sp_we) begin
                chk("R10", "base write without dst write", 64'd1, 64'd0);
            end
            if (undecoded) begin
                if (q.size() == 0) chk("R9", "unexpected undecoded", 64'd1, 64'd0);
                else begin
                    chk(q[0].req, "undecoded kind", 64'(K_UNDEC), 64'(q[0].kind));
                    void'(q.pop_front());
                end
            end
            if (align_fault) begin
                if (q.size() == 0) chk("R6", "unexpected align_fault", 64'd1, 64'd0);
                else begin
                    chk(q[0].req, "align_fault kind", 64'(K_FAULT), 64'(q[0].kind));
                    void'(q.pop_front());
                end
            end
        end
    end

    // driver: pushes the expected item, then plays the instruction and memory sides
    task automatic run(exp_t e, logic [31:0] w, logic [63:0] gpr, logic [63:0] sp,
                       int lat, logic [7:0] b, bit poke);
        q.push_back(e);
        @(posedge clk); #1;
        instr_word = w; instr_valid = 1'b1; rd_data = gpr; sp_in = sp;
        @(negedge clk);
        if (e.kind != K_UNDEC) chk("R5", "rd_idx", 64'(rd_idx), 64'(w[9:5]));
        @(posedge clk); #1;
        instr_valid = 1'b0;
        if (e.kind == K_LOAD) begin
            chk("R10", "busy after accept", 64'(busy), 64'd1);
            @(posedge clk); #1;
            for (int i = 0; i < lat; i++) begin
                if (poke) begin
                    instr_word = enc(F_UOFS, 5'd1, 5'd2, 12'h3);
                    instr_valid = 1'b1;
                end
                @(posedge clk); #1;
                instr_valid = 1'b0;
            end
            mem_rdata = b; mem_rvalid = 1'b1;
            @(posedge clk); #1;
            mem_rvalid = 1'b0;
            chk("R10", "busy after completion", 64'(busy), 64'd0);
        end else begin
            @(posedge clk); #1;
            chk(e.req, "busy stays low", 64'(busy), 64'd0);
        end
        if (q.size() != 0) begin
            chk(e.req, "result missing", 64'(q.size()), 64'd0);
            q.delete();
        end
        req_seen = 0;
    endtask

    task automatic ld(string req, int form, logic [4:0] n, logic [4:0] t, int imm,
                      logic [63:0] gpr, logic [63:0] sp, int lat, logic [7:0] b, bit poke);
        exp_t e;
        e = model(req, form, n, t, imm, gpr, sp, b);
        run(e, enc(form, n, t, 12'(imm)), gpr, sp, lat, b, poke);
    endtask

    task automatic bad_word(logic [31:0] w);
        exp_t e;
        e.kind = K_UNDEC; e.req = "R9"; e.addr = '0; e.t = '0; e.data = '0;
        e.wb_kind = 0; e.n = '0; e.wbv = '0;
        run(e, w, 64'h0, 64'h0, 0, 8'h0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R11", "busy", 64'(busy), 64'd0);
        chk("R11", "mem_req", 64'(mem_req), 64'd0);
        chk("R11", "writes", 64'({dst_we, wb_we, sp_we}), 64'd0);
        chk("R11", "flags", 64'({undecoded, align_fault}), 64'd0);

        ld("R1", F_POST, 5'd3, 5'd5, 16, 64'h1000, 64'h0, 1, 8'h3C, 0);
        ld("R1", F_POST, 5'd0, 5'd7, -4, 64'hFFFF_0000_0000_0002, 64'h0, 0, 8'h01, 0);
        ld("R2", F_PRE, 5'd7, 5'd2, -1, 64'h2000, 64'h0, 2, 8'h80, 0);
        ld("R4", F_PRE, 5'd8, 5'd1, -256, 64'h500, 64'h0, 1, 8'h11, 0);
        ld("R4", F_POST, 5'd9, 5'd1, 255, 64'h700, 64'h0, 3, 8'h22, 0);
        ld("R3", F_UOFS, 5'd4, 5'd9, 4095, 64'h1_0000, 64'h0, 1, 8'h44, 0);
        ld("R3", F_UOFS, 5'd10, 5'd11, 0, 64'hDEAD_BEEF, 64'h0, 0, 8'h55, 0);
        ld("R7", F_UOFS, 5'd12, 5'd30, 7, 64'h40, 64'h0, 1, 8'hFF, 0);
        ld("R5", F_PRE, 5'd31, 5'd3, -16, 64'h9999, 64'h8000, 1, 8'h66, 0);
        ld("R5", F_POST, 5'd31, 5'd4, 32, 64'h9999, 64'h7_0010, 2, 8'h67, 0);
        ld("R5", F_UOFS, 5'd31, 5'd6, 100, 64'h9999, 64'h100, 1, 8'h68, 0);
        ld("R6", F_PRE, 5'd31, 5'd2, 16, 64'h0, 64'h8008, 0, 8'h0, 0);
        ld("R6", F_UOFS, 5'd31, 5'd2, 16, 64'h0, 64'h8001, 0, 8'h0, 0);
        ld("R8", F_PRE, 5'd6, 5'd6, 8, 64'h3000, 64'h0, 1, 8'h77, 0);
        ld("R8", F_POST, 5'd13, 5'd13, -8, 64'h3100, 64'h0, 1, 8'h78, 0);
        ld("R8", F_PRE, 5'd31, 5'd31, 16, 64'h0, 64'h4000, 1, 8'h79, 0);
        bad_word(32'h0000_0000);
        bad_word({11'b00111000010, 9'h010, 2'b00, 5'd1, 5'd2});
        bad_word({11'b00111000010, 9'h010, 2'b10, 5'd1, 5'd2});
        bad_word({10'b0011100111, 12'h010, 5'd1, 5'd2});
        ld("R10", F_UOFS, 5'd14, 5'd15, 9, 64'h5000, 64'h0, 4, 8'h9A, 1);
        ld("R2", F_PRE, 5'd16, 5'd17, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 8'hAB, 0);

        repeat (2) @(posedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule